// File: doc/BRIEF.md
# Sync-Triggered Conversion Scheduler

This block turns each PWM synchronisation event into an ordered burst of A/D conversion requests. When a sync edge is accepted, the block requests the current-feedback channels first, in ascending order. It then requests exactly one auxiliary analog input. The auxiliary inputs are visited in rotation, so each of the six is refreshed once every six sync events. Requests go to an external conversion engine over a start/busy/done handshake. Each returned 12-bit result lands in a per-channel register, together with a new-data flag.

The block also drives a stretched sync output pulse and a one-cycle PWM update strobe. A sync edge that arrives while a burst is still running is not acted on; it only raises an overrun strobe. Software-side consumers read results through a select/read port, and a read clears that channel's flag.

Top module: `adc_sync_sched`

## Requirements
- R1: After an accepted sync edge, `sync_out` is high for exactly SYNC_W (default 32) consecutive cycles, starting one clock after the edge is sampled.
- R2: `pwm_upd` is a single-cycle strobe, one clock after an accepted sync edge, which is within the 2-clock bound.
- R3: Each burst issues the current channels in ascending order, with codes 0 to N_CUR-1, before any auxiliary request.
- R4: Each burst's final request is an auxiliary input. Auxiliary input k (1 to 6) uses channel code N_CUR+k-1. The input index advances by one per accepted sync, starts at 1 after reset and wraps from 6 to 1.
- R5: A request is issued only while `conv_busy` is low, and only one request is outstanding at a time.
- R6: With the bench engine latency, the last current result is written within 100 cycles of the sync edge, and the auxiliary result within 200 cycles.
- R7: On `conv_done`, the result register and the new-data flag of the requested channel are both updated on the same edge. `rd_data`/`rd_new` show the selected channel's register and flag.
- R8: A read clears the selected channel's flag. If a result for that channel is written on the same edge, the flag stays set.
- R9: A sync edge during a running burst pulses `overrun` for one cycle. It leaves the channel order, `sync_out` and `pwm_upd` unchanged.
- R10: After reset, all flags and results are zero, and `sync_out`, `pwm_upd`, `overrun` and `conv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | PWM sync request; its rising edge triggers a burst |
| conv_busy | input | 1 | Conversion engine cannot take a request |
| conv_done | input | 1 | Engine result valid, one cycle |
| conv_data | input | DW (12) | Engine result |
| conv_start | output | 1 | Conversion request, one cycle |
| conv_chan | output | CH_W (3) | Channel code of the request |
| sync_out | output | 1 | Stretched sync pulse |
| pwm_upd | output | 1 | PWM update strobe |
| overrun | output | 1 | Sync ignored during a burst |
| rd_en | input | 1 | Read strobe, clears the selected flag |
| rd_sel | input | CH_W (3) | Read channel select |
| rd_data | output | DW (12) | Selected result |
| rd_new | output | 1 | Selected channel's new-data flag |
| new_flags | output | N_CH (8) | All new-data flags |

## Verification
Two functions can fall on the same clock edge. The first pair is a result write and a read-clear of the same channel's flag. The bench provokes it by waiting for the cycle in which its engine model raises `conv_done`, then asserting `rd_en` with `rd_sel` equal to that channel; it expects the flag to remain set (R8). The second pair is a fresh sync edge and the completion of the auxiliary conversion that ends a burst. That sync must count as an overrun, since the burst is still active on that edge, and the reference model judges it that way every cycle.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/adc_sync_pulse.sv
module adc_sync_pulse #(
    parameter int SYNC_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic sync_out,
    output logic pwm_upd
);
    localparam int CW = $clog2(SYNC_W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          upd;
    } pls_t;

    pls_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.upd = accept;
        if (accept)
            r_d.cnt = CW'(SYNC_W);
        else if (r_q.cnt != '0)
            r_d.cnt = r_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_out = (r_q.cnt != '0);
    assign pwm_upd  = r_q.upd;

    // R1: the stretched pulse only starts together with the update strobe
    p_pulse_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> pwm_upd);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_sched_pkg::*;
#(
    parameter int N_CUR   = 2,
    parameter int N_AUX   = 6,
    parameter int CH_W    = 3,
    parameter int DW      = 12,
    parameter int CUR_LIM = 100,
    parameter int AUX_LIM = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_rise,
    input  logic            conv_busy,
    input  logic            conv_done,
    input  logic [DW-1:0]   conv_data,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            wr_en,
    output logic [CH_W-1:0] wr_chan,
    output logic [DW-1:0]   wr_data,
    output logic            accept,
    output logic            ovr
);
    localparam int IDX_W = $clog2(N_CUR + 1);
    localparam int AUX_W = (N_AUX > 1) ? $clog2(N_AUX) : 1;
    localparam int CNT_W = $clog2(AUX_LIM + 2) + 1;

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [AUX_W-1:0] aux;
        logic             ovr;
        logic [CNT_W-1:0] elap;
    } ctl_t;

    ctl_t r_d, r_q;
    logic on_aux;

    always_comb begin
        r_d        = r_q;
        r_d.ovr    = 1'b0;
        accept     = 1'b0;
        conv_start = 1'b0;
        wr_en      = 1'b0;
        on_aux     = (r_q.idx == IDX_W'(N_CUR));
        conv_chan  = on_aux ? (CH_W'(N_CUR) + CH_W'(r_q.aux)) : CH_W'(r_q.idx);
        wr_chan    = conv_chan;
        wr_data    = conv_data;
        if (r_q.elap != '1)
            r_d.elap = r_q.elap + 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sync_rise) begin
                    accept   = 1'b1;
                    r_d.st   = ST_ISSUE;
                    r_d.idx  = '0;
                    r_d.elap = '0;
                end
            end
            ST_ISSUE: begin
                if (!conv_busy) begin
                    conv_start = 1'b1;
                    r_d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (conv_done) begin
                    wr_en = 1'b1;
                    if (on_aux) begin
                        r_d.st  = ST_IDLE;
                        r_d.aux = (r_q.aux == AUX_W'(N_AUX - 1)) ? '0 : r_q.aux + 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_ISSUE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (sync_rise && (r_q.st != ST_IDLE))
            r_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign ovr = r_q.ovr;

    // R3: every requested code names an existing channel
    p_chan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (int'(conv_chan) < N_CUR + N_AUX));
    // R4: the rotation index never leaves the auxiliary range
    p_aux_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(r_q.aux) < N_AUX);
    // R6: current-feedback results land inside their window
    p_cur_deadline_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && conv_done && !on_aux) |-> (r_q.elap < CNT_W'(CUR_LIM)));
    // R6: auxiliary result lands inside its window
    p_aux_deadline_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && conv_done && on_aux) |-> (r_q.elap < CNT_W'(AUX_LIM)));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int N_CH = 8,
    parameter int CH_W = 3,
    parameter int DW   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_chan,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_en,
    input  logic [CH_W-1:0] rd_sel,
    output logic [DW-1:0]   rd_data,
    output logic            rd_new,
    output logic [N_CH-1:0] new_flags
);
    typedef struct packed {
        logic [N_CH-1:0][DW-1:0] res;
        logic [N_CH-1:0]         flg;
    } bank_t;

    bank_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < N_CH; i++) begin
            if (rd_en && (int'(rd_sel) == i))
                r_d.flg[i] = 1'b0;
            if (wr_en && (int'(wr_chan) == i)) begin
                r_d.res[i] = wr_data;
                r_d.flg[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        rd_new  = 1'b0;
        if (int'(rd_sel) < N_CH) begin
            rd_data = r_q.res[rd_sel];
            rd_new  = r_q.flg[rd_sel];
        end
    end

    assign new_flags = r_q.flg;

    // R7: a written channel shows its flag on the next cycle
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> new_flags[$past(wr_chan)]);
endmodule

// File: rtl/adc_sync_sched.sv
module adc_sync_sched #(
    parameter int N_CUR   = 2,
    parameter int N_AUX   = 6,
    parameter int DW      = 12,
    parameter int SYNC_W  = 32,
    parameter int CUR_LIM = 100,
    parameter int AUX_LIM = 200,
    localparam int N_CH   = N_CUR + N_AUX,
    localparam int CH_W   = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_in,
    input  logic            conv_busy,
    input  logic            conv_done,
    input  logic [DW-1:0]   conv_data,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            sync_out,
    output logic            pwm_upd,
    output logic            overrun,
    input  logic            rd_en,
    input  logic [CH_W-1:0] rd_sel,
    output logic [DW-1:0]   rd_data,
    output logic            rd_new,
    output logic [N_CH-1:0] new_flags
);
    typedef struct packed {
        logic prev;
    } edg_t;

    edg_t e_d, e_q;
    logic            sync_rise, accept, wr_en;
    logic [CH_W-1:0] wr_chan;
    logic [DW-1:0]   wr_data;

    always_comb begin
        e_d.prev  = sync_in;
        sync_rise = sync_in & ~e_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    adc_seq_ctrl #(
        .N_CUR(N_CUR), .N_AUX(N_AUX), .CH_W(CH_W), .DW(DW),
        .CUR_LIM(CUR_LIM), .AUX_LIM(AUX_LIM)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise),
        .conv_busy(conv_busy), .conv_done(conv_done), .conv_data(conv_data),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
        .accept(accept), .ovr(overrun)
    );

    adc_sync_pulse #(.SYNC_W(SYNC_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .sync_out(sync_out), .pwm_upd(pwm_upd)
    );

    adc_result_bank #(.N_CH(N_CH), .CH_W(CH_W), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .rd_new(rd_new), .new_flags(new_flags)
    );

    // R9: an ignored sync never coincides with a restart strobe
    p_ovr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !pwm_upd);
    // R2: the update strobe lasts a single cycle
    p_upd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_upd |=> !pwm_upd);
endmodule

// File: tb/adc_sync_sched_bench.sv
module adc_sync_sched_bench;
    localparam int N_CUR = 2, N_AUX = 6, N_CH = 8, DW = 12, SW = 32, LAT = 20;

    logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0;
    logic conv_done = 1'b0, rd_en = 1'b0, hold_busy = 1'b0;
    logic eng_busy = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic [2:0] rd_sel = '0, eng_chan = '0;
    logic conv_busy, conv_start, sync_out, pwm_upd, overrun, rd_new;
    logic [2:0] conv_chan;
    logic [DW-1:0] rd_data;
    logic [N_CH-1:0] new_flags;

    int checks = 0, errors = 0, eng_cnt = 0, seq = 0, cycles = 0;

    always #4 clk = ~clk;
    assign conv_busy = eng_busy | hold_busy;

    adc_sync_sched u_adc_sync_sched (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .conv_busy(conv_busy),
        .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
        .conv_chan(conv_chan), .sync_out(sync_out), .pwm_upd(pwm_upd),
        .overrun(overrun), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .rd_new(rd_new), .new_flags(new_flags)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // conversion engine model
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            eng_busy <= 1'b1;
            eng_cnt  <= LAT;
            eng_chan <= conv_chan;
        end else if (eng_busy) begin
            if (eng_cnt == 1) begin
                eng_busy  <= 1'b0;
                conv_done <= 1'b1;
                conv_data <= {eng_chan, 9'(seq)};
                seq       <= seq + 1;
            end else begin
                eng_cnt <= eng_cnt - 1;
            end
        end
    end

    // behavioural reference model
    bit m_busy, m_pwm, m_ovr, s_prev;
    int m_aux, m_pulse, m_elap;
    logic [DW-1:0] m_res [N_CH];
    logic [N_CH-1:0] m_flag;
    int exp_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_pwm = 0; m_ovr = 0; s_prev = 0;
            m_aux = 0; m_pulse = 0; m_elap = 0; m_flag = '0;
            foreach (m_res[i]) m_res[i] = '0;
            exp_q.delete();
        end else begin
            bit rise;
            rise = sync_in && !s_prev;
            s_prev = sync_in;
            m_ovr = 0; m_pwm = 0;
            if (m_pulse > 0) m_pulse--;
            if (rise) begin
                if (m_busy) m_ovr = 1;
                else begin
                    m_busy = 1; m_pulse = SW; m_pwm = 1; m_elap = 0;
                    for (int c = 0; c < N_CUR; c++) exp_q.push_back(c);
                    exp_q.push_back(N_CUR + m_aux);
                    m_aux = (m_aux + 1) % N_AUX;
                end
            end
            if (conv_start) begin
                int e;
                chk(!conv_busy, "R5", conv_busy, 0);
                e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                chk(int'(conv_chan) == e, (e < N_CUR) ? "R3" : "R4", conv_chan, e);
            end
            if (rd_en) m_flag[rd_sel] = 1'b0;
            if (conv_done) begin
                if (eng_chan >= N_CUR) begin
                    chk(m_elap <= 200, "R6", m_elap, 200);
                    m_busy = 0;
                end else begin
                    chk(m_elap <= 100, "R6", m_elap, 100);
                end
                m_res[eng_chan] = conv_data;
                m_flag[eng_chan] = 1'b1;
            end
            m_elap++;
        end
    end

    // per-cycle comparison away from the active edge
    bit run_cmp = 0;
    always @(negedge clk) begin
        if (run_cmp) begin
            chk(sync_out == (m_pulse > 0), "R1", sync_out, m_pulse > 0);
            chk(pwm_upd == m_pwm, "R2", pwm_upd, m_pwm);
            chk(overrun == m_ovr, "R9", overrun, m_ovr);
            chk(new_flags == m_flag, "R7", new_flags, m_flag);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic pulse_sync();
        @(negedge clk) sync_in = 1'b1;
        @(negedge clk) sync_in = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_chk(input int ch);
        @(negedge clk);
        rd_sel = 3'(ch);
        #1;
        chk(rd_data == m_res[ch], "R7", rd_data, m_res[ch]);
        chk(rd_new == m_flag[ch], "R7", rd_new, m_flag[ch]);
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        chk(new_flags[ch] == 1'b0, "R8", new_flags[ch], 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sync_out == 0 && pwm_upd == 0 && overrun == 0, "R10", {sync_out, pwm_upd, overrun}, 0);
        chk(new_flags == '0 && rd_data == '0, "R10", new_flags, 0);
        chk(conv_start == 0, "R10", conv_start, 0);
        run_cmp = 1;

        // two full wraps of the auxiliary rotation
        for (int k = 0; k < 13; k++) begin
            pulse_sync();
            wait_cyc(90);
            if (k % 3 == 0) read_chk(k % N_CH);
        end

        // R9: sync during a running burst
        pulse_sync();
        wait_cyc(30);
        pulse_sync();
        wait_cyc(90);

        // R5: engine held busy when the burst starts
        hold_busy = 1'b1;
        pulse_sync();
        wait_cyc(15);
        hold_busy = 1'b0;
        wait_cyc(100);

        // R8: read-clear on the same edge as a result write
        pulse_sync();
        do @(negedge clk); while (!conv_done);
        rd_sel = eng_chan;
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        chk(new_flags[rd_sel] == 1'b1, "R8", new_flags[rd_sel], 1);
        wait_cyc(90);

        // R9: new sync on the edge the burst finishes
        pulse_sync();
        do @(negedge clk); while (!(conv_done && eng_chan >= N_CUR));
        sync_in = 1'b1;
        @(negedge clk) sync_in = 1'b0;
        chk(overrun == 1'b1, "R9", overrun, 1);
        wait_cyc(20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule